// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a station-management master for one MDC/MDIO serial management bus. Software programs it through four 32-bit registers: a clock/format register, a command register, a write-data register and a read-data register. Each write to the command register, made while the bus is idle, produces exactly one serial management frame. The frame is either a clause 22 frame or a clause 45 frame, as the format bit selects. The block generates MDC from the system clock through a programmable divider. It shifts the frame out on MDIO and, for reads, releases the line from the turnaround onward and captures the 16 data bits returned by the PHY.

Completion is reported through pending flags. The write-data register carries the pending flag for write and address frames. The read-data register carries the pending flag for read frames, together with a valid flag and the returned data. Longer clause 45 sequences, such as an address frame followed by a read, are built by software from single frames.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register 0 (clock/format) holds the MDC half period in bits [7:0], the format bit in bit 8 (0 = clause 22, 1 = clause 45) and the preamble-enable bit in bit 9. A write with bit 8 set also sets the preamble-enable bit. After reset the register reads 0x004. Each MDC level lasts (half period + 1) system clocks, and MDC is low whenever no frame is running.
- R2: A write to register 1 (command) while idle starts one frame, with op in bits [1:0], port address in bits [6:2] and register/device address in bits [11:7]. A command written while a frame is in progress is ignored: the running frame is unchanged and no further frame follows.
- R3: In clause 22 format the frame is start 01, op code 01 for a write (command op bit 0 = 0) or 10 for a read (command op bit 0 = 1), then the 5-bit port address and the 5-bit register address, MSB first.
- R4: In clause 45 format the frame is start 00, then the wire op code equal to the command op (0 address, 1 write, 2 read with post-increment, 3 read), then the port address and the 5-bit device address from command bits [11:7]. The 16-bit field of an address frame is taken from the write-data register.
- R5: When preamble-enable is set, 32 one bits precede the start bits. When it is clear, the frame begins directly with the start bits.
- R6: MDIO drive and output-enable change only as MDC falls, and MDIO input is sampled on the system clock at which MDC rises.
- R7: Write and address frames drive turnaround 10 and then the 16 bits of register 2 (write-data, bits [15:0]), MSB first. Register 2 bit 16 (pending) is set from the start until the end of the frame.
- R8: Read frames release MDIO (output enable low) from the first turnaround bit to the end of the frame. The 16 data bits are captured MSB first. Register 3 bit 17 (pending) is set during the frame. Bit 16 (valid) ends as 1 only if MDIO was 0 in the second turnaround bit. At most one pending flag is set at a time.
- R9: Register 3 bits [15:0] (read data) and bit 16 (valid) change only at the end of a read frame, in the same clock as its pending flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The checker checks several properties on every cycle. MDC stays low while idle. The MDIO drive changes only on a falling MDC. A pending flag rises only when a frame starts from idle, and the two pending flags are never set together. Read data and valid change only when the read pending flag falls. The bench's scenarios show the serial content of every frame, for both formats, all op codes, and with and without the preamble. The bench also shows the measured MDC period, the captured read data and its valid flag when the turnaround is good and when it is bad, and that a command issued mid-frame leaves no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    // register selects
    localparam logic [1:0] SEL_CLK  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_WDAT = 2'd2;
    localparam logic [1:0] SEL_RDAT = 2'd3;

    // field positions
    localparam int CLK_DIV_LSB  = 0;
    localparam int CLK_MODE_BIT = 8;
    localparam int CLK_PRE_BIT  = 9;
    localparam int CMD_OP_LSB   = 0;
    localparam int CMD_PORT_LSB = 2;
    localparam int CMD_REG_LSB  = 7;
    localparam int WDAT_PEND_BIT = 16;
    localparam int RDAT_VAL_BIT  = 16;
    localparam int RDAT_PEND_BIT = 17;

    // frame geometry
    localparam int DATA_LEN  = 16;
    localparam int ADDR_LEN  = 5;
    localparam int FRAME_LEN = 32;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t div_q, div_d;
    logic wrap;

    always_comb begin
        div_d = div_q;
        wrap  = run && (div_q.cnt == half_div);
        if (!run) begin
            div_d.cnt = '0;
            div_d.lvl = 1'b0;
        end else if (wrap) begin
            div_d.cnt = '0;
            div_d.lvl = ~div_q.lvl;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc      = div_q.lvl;
    assign rise_stb = wrap && !div_q.lvl;
    assign fall_stb = wrap &&  div_q.lvl;
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
(
    input  logic                 c45,
    input  logic [1:0]           op,
    input  logic [ADDR_LEN-1:0]  port_ad,
    input  logic [ADDR_LEN-1:0]  reg_ad,
    input  logic [DATA_LEN-1:0]  wdat,
    output logic [FRAME_LEN-1:0] frame,
    output logic                 is_read
);
    logic [1:0] st_bits;
    logic [1:0] op_bits;
    logic [DATA_LEN+1:0] tail;

    always_comb begin
        if (c45) begin
            st_bits = 2'b00;
            op_bits = op;
            is_read = op[1];
        end else begin
            st_bits = 2'b01;
            is_read = op[0];
            op_bits = op[0] ? 2'b10 : 2'b01;
        end
        // released bits are carried as ones
        tail  = is_read ? '1 : {2'b10, wdat};
        frame = {st_bits, op_bits, port_ad, reg_ad, tail};
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int           DIV_W        = 8,
    parameter int           REG_W        = 32,
    parameter int           PRE_LEN      = 32,
    parameter logic [7:0]   RST_HALF_DIV = 8'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int SH_LEN = PRE_LEN + FRAME_LEN;
    localparam int REM_W  = $clog2(SH_LEN + 1);
    localparam logic [REM_W-1:0] REM_LAST  = REM_W'(1);
    localparam logic [REM_W-1:0] REM_TA1   = REM_W'(DATA_LEN + 2);
    localparam logic [REM_W-1:0] REM_TA2   = REM_W'(DATA_LEN + 1);
    localparam logic [REM_W-1:0] REM_DATA  = REM_W'(DATA_LEN);
    localparam logic [REM_W-1:0] REM_FULL  = REM_W'(SH_LEN);
    localparam logic [REM_W-1:0] REM_SHORT = REM_W'(FRAME_LEN);

    typedef struct packed {
        logic [DIV_W-1:0]    half_div;
        logic                c45;
        logic                pre_en;
        logic [DATA_LEN-1:0] wdat;
        logic                busy;
        logic                rd_op;
        logic [SH_LEN-1:0]   shift;
        logic [REM_W-1:0]    rem;
        logic [DATA_LEN-1:0] rd_shift;
        logic                ta_ok;
        logic                wr_pend;
        logic                rd_pend;
        logic                rd_valid;
        logic [DATA_LEN-1:0] rd_data;
    } eng_t;

    eng_t q, d;

    logic                 rise_stb, fall_stb;
    logic [FRAME_LEN-1:0] fmt_frame;
    logic                 fmt_rd;

    mdio_mdc_div #(.DIV_W(DIV_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.busy),
        .half_div (q.half_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_fmt fmt_i (
        .c45     (q.c45),
        .op      (reg_wdata[CMD_OP_LSB +: 2]),
        .port_ad (reg_wdata[CMD_PORT_LSB +: ADDR_LEN]),
        .reg_ad  (reg_wdata[CMD_REG_LSB +: ADDR_LEN]),
        .wdat    (q.wdat),
        .frame   (fmt_frame),
        .is_read (fmt_rd)
    );

    always_comb begin
        d = q;
        // register writes
        if (reg_wr) begin
            case (reg_addr)
                SEL_CLK: begin
                    d.half_div = reg_wdata[CLK_DIV_LSB +: DIV_W];
                    d.c45      = reg_wdata[CLK_MODE_BIT];
                    d.pre_en   = reg_wdata[CLK_PRE_BIT] | reg_wdata[CLK_MODE_BIT];
                end
                SEL_WDAT: d.wdat = reg_wdata[DATA_LEN-1:0];
                SEL_CMD: begin
                    if (!q.busy) begin
                        d.busy     = 1'b1;
                        d.rd_op    = fmt_rd;
                        d.shift    = q.pre_en ? {{PRE_LEN{1'b1}}, fmt_frame}
                                              : {fmt_frame, {PRE_LEN{1'b0}}};
                        d.rem      = q.pre_en ? REM_FULL : REM_SHORT;
                        d.ta_ok    = 1'b0;
                        d.wr_pend  = !fmt_rd;
                        d.rd_pend  = fmt_rd;
                    end
                end
                default: ;
            endcase
        end
        // serial engine
        if (q.busy) begin
            if (rise_stb && q.rd_op) begin
                if (q.rem == REM_TA2)
                    d.ta_ok = !mdio_i;
                if (q.rem <= REM_DATA)
                    d.rd_shift = {q.rd_shift[DATA_LEN-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (q.rem == REM_LAST) begin
                    d.busy    = 1'b0;
                    d.wr_pend = 1'b0;
                    d.rd_pend = 1'b0;
                    if (q.rd_op) begin
                        d.rd_data  = q.rd_shift;
                        d.rd_valid = q.ta_ok;
                    end
                end else begin
                    d.shift = {q.shift[SH_LEN-2:0], 1'b0};
                    d.rem   = q.rem - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.half_div <= DIV_W'(RST_HALF_DIV);
        end else begin
            q <= d;
        end
    end

    assign mdio_o  = q.busy ? q.shift[SH_LEN-1] : 1'b1;
    assign mdio_oe = q.busy && (!q.rd_op || (q.rem > REM_TA1));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CLK: begin
                reg_rdata[CLK_DIV_LSB +: DIV_W] = q.half_div;
                reg_rdata[CLK_MODE_BIT]         = q.c45;
                reg_rdata[CLK_PRE_BIT]          = q.pre_en;
            end
            SEL_WDAT: begin
                reg_rdata[DATA_LEN-1:0]  = q.wdat;
                reg_rdata[WDAT_PEND_BIT] = q.wr_pend;
            end
            SEL_RDAT: begin
                reg_rdata[DATA_LEN-1:0]  = q.rd_data;
                reg_rdata[RDAT_VAL_BIT]  = q.rd_valid;
                reg_rdata[RDAT_PEND_BIT] = q.rd_pend;
            end
            default: ;
        endcase
    end

    // observation points for the bound checker
    logic                busy_w, wr_pend_w, rd_pend_w, rd_valid_w;
    logic [DATA_LEN-1:0] rd_data_w;
    assign busy_w     = q.busy;
    assign wr_pend_w  = q.wr_pend;
    assign rd_pend_w  = q.rd_pend;
    assign rd_valid_w = q.rd_valid;
    assign rd_data_w  = q.rd_data;
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        wr_pend,
    input logic        rd_pend,
    input logic        rd_valid,
    input logic [15:0] rd_data
);
    assert_idle_mdc_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_no_start_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_pend) || $rose(rd_pend)) |-> !$past(busy));

    assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) &&
         ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe)))) |-> $fell(mdc));

    assert_one_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pend, rd_pend}));

    assert_pending_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wr_pend || rd_pend));

    assert_read_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_data) || !$stable(rd_valid)) |-> $fell(rd_pend));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .wr_pend  (wr_pend_w),
    .rd_pend  (rd_pend_w),
    .rd_valid (rd_valid_w),
    .rd_data  (rd_data_w)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] exp_frame(input bit c45, input logic [1:0] op,
        input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        logic [1:0] st, oc;
        bit rd;
        if (c45) begin st = 2'b00; oc = op; rd = op[1]; end
        else begin st = 2'b01; rd = op[0]; oc = rd ? 2'b10 : 2'b01; end
        return {st, oc, pa, ra, (rd ? 18'h3FFFF : {2'b10, wd})};
    endfunction

    function automatic bit phy_bit(input int i, input int off, input bit rd,
        input bit ta_good, input logic [15:0] pd);
        int k = i - off;
        if (!rd || k < 14) return 1'b1;
        if (k == 14) return 1'b1;
        if (k == 15) return ta_good ? 1'b0 : 1'b1;
        return pd[31 - k];
    endfunction

    task automatic run_frame(input bit c45, input bit pre, input logic [7:0] div,
        input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
        input logic [15:0] wd, input logic [15:0] pd, input bit ta_good, input bit inject);
        logic [31:0] fr, v, prev_rd;
        bit rd, pre_eff;
        int off, nbits, t0, errs, first_bad;
        logic [1:0] got_b, exp_b;
        pre_eff = pre | c45;
        wr_reg(2'd0, {22'd0, pre, c45, div});
        wr_reg(2'd2, {16'd0, wd});
        rd_reg(2'd3, prev_rd);
        fr = exp_frame(c45, op, pa, ra, wd);
        rd = c45 ? op[1] : op[0];
        off = pre_eff ? 32 : 0;
        nbits = off + 32;
        errs = 0; first_bad = -1; got_b = '0; exp_b = '0; t0 = 0;
        mdio_i = phy_bit(0, off, rd, ta_good, pd);
        wr_reg(2'd1, {20'd0, ra, pa, op});
        if (inject) wr_reg(2'd1, {20'd0, ~ra, ~pa, ~op});
        for (int i = 0; i < nbits; i++) begin
            logic [1:0] e;
            int k;
            @(posedge mdc);
            #0.5;
            k = i - off;
            if (k < 0) e = 2'b11;
            else if (rd && k >= 14) e = {1'b0, 1'b0};
            else e = {1'b1, fr[31 - k]};
            if ((e[1] == 1'b0 && mdio_oe !== 1'b0) ||
                (e[1] == 1'b1 && {mdio_oe, mdio_o} !== e)) begin
                errs++;
                if (first_bad < 0) begin first_bad = i; got_b = {mdio_oe, mdio_o}; exp_b = e; end
            end
            if (i == 0) t0 = cyc;
            if (i == 1) check("R1 MDC period", 32'(cyc - t0), 32'(2 * (int'(div) + 1)));
            if (i == 2) begin
                rd_reg(rd ? 2'd3 : 2'd2, v);
                check(rd ? "R8 read pending" : "R7 write pending",
                      32'(rd ? v[17] : v[16]), 32'd1);
                if (rd) check("R9 data held during read", v[16:0], prev_rd[16:0]);
            end
            @(negedge mdc);
            mdio_i = phy_bit(i + 1, off, rd, ta_good, pd);
        end
        if (errs != 0)
            $display("FAIL R3/R4/R5/R6 bit %0d got %b exp %b (%0d bad bits)", first_bad, got_b, exp_b, errs);
        n_chk++;
        if (errs != 0) n_bad++;
        repeat (3) @(negedge clk);
        mdio_i = 1'b1;
        if (rd) begin
            rd_reg(2'd3, v);
            check("R8/R9 read result", v[17:0], {1'b0, ta_good, pd});
        end else begin
            rd_reg(2'd2, v);
            check("R7 write pending cleared", v[16:0], {1'b0, wd});
        end
        if (inject) begin
            repeat (40) @(negedge clk);
            check("R2 no second frame mdc", 32'(mdc), 32'd0);
            rd_reg(2'd2, v);
            check("R2 no second frame pending", 32'(v[16]), 32'd0);
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R1 reset mdc", 32'(mdc), 32'd0);
        check("R1 reset oe", 32'(mdio_oe), 32'd0);
        rd_reg(2'd0, v); check("R1 reset clk reg", v, 32'h004);
        rd_reg(2'd2, v); check("R7 reset wdata reg", v, 32'h0);
        rd_reg(2'd3, v); check("R8 reset rdata reg", v, 32'h0);
        // format bit forces preamble
        wr_reg(2'd0, 32'h102);
        rd_reg(2'd0, v); check("R1 c45 sets preamble", v, 32'h302);
        wr_reg(2'd0, 32'h003);
        rd_reg(2'd0, v); check("R1 c22 keeps written value", v, 32'h003);
        // directed corner cases
        run_frame(0, 0, 8'd1, 2'd0, 5'h1F, 5'h00, 16'hA55A, 16'h0, 1, 0);  // R3 write
        run_frame(0, 1, 8'd0, 2'd1, 5'h03, 5'h11, 16'h0, 16'hBEEF, 1, 0);  // R3 read, R5
        run_frame(1, 0, 8'd2, 2'd0, 5'h05, 5'h1D, 16'h1234, 16'h0, 1, 0);  // R4 address
        run_frame(1, 1, 8'd1, 2'd3, 5'h05, 5'h01, 16'h0, 16'h8001, 1, 0);  // R4 read
        run_frame(1, 1, 8'd1, 2'd2, 5'h00, 5'h1F, 16'h0, 16'h7FFE, 0, 0);  // R8 bad TA
        run_frame(0, 0, 8'd3, 2'd0, 5'h0A, 5'h0B, 16'hC0DE, 16'h0, 1, 1);  // R2 inject
        run_frame(0, 0, 8'd3, 2'd1, 5'h0A, 5'h0B, 16'h0, 16'h4321, 1, 1);  // R2 inject on read
        // random traffic
        void'($urandom(32'h5EED1234));
        for (int n = 0; n < 30; n++) begin
            run_frame($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom_range(0, 3)),
                      2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                      16'($urandom), ($urandom_range(0, 4) != 0), 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got %0d exp below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule